// File: doc/BRIEF.md
# Serialized IRQ slave frame generator

This block is the peripheral end of a serialized interrupt link. It shares one low-active IRQ/data line with a host and with other peripherals, and all of them run on the host bus clock. The block follows the line to find start frames and stop frames. Between them it counts three-clock IRQ frames. In the frames it owns, it drives the request pattern for three interrupt sources: IRQ1, IRQ12 and one IRQx frame whose number is set on an input.

The requests come directly from two output-buffer-full flags. An 8-bit control register, cleared by reset, sets the routing of these flags to the frames, mutes the IRQ1 and IRQ12 frames, and selects the IRQx polarity. The same register also controls a clock-run sideband that the block can only pull low. The block pulls it low to keep the host clock from stopping, or to ask for the clock to restart while a request is pending. In quiet mode the block opens a new cycle itself with a one-clock low pulse when a request rises, and the host then completes the start frame.

The lines are open-drain. A pull-up outside the block resolves them high when nobody drives. The block therefore presents each line as a drive enable, a drive value and a sampled input.

Top module: `sirq_slave`

## Requirements
- R1: After reset the control register reads as zero and neither the IRQ/data line nor the clock-run line is driven. While cfg_we is high, the rising edge loads cfg_wdata into the register.
- R2: While control bit 0 (interface enable) is 0, neither line is driven, whatever the other bits, the flags or the line activity are.
- R3: With the interface enabled and the block idle, a low run of 4 to 8 line samples followed by a high sample starts frame counting. A run of 3 samples, or of 9 or more, starts nothing, and no frame is driven after it.
- R4: Frame 1 is driven low, then high, then released when control bit 3 is 1, obf0 is 1 and bit 6 is 0. Otherwise the line is left floating in all three clocks of frame 1.
- R5: Frame 12 follows the same rule as frame 1, with control bit 4 in place of bit 3.
- R6: When control bit 6 is 1, frames 1 and 12 float whatever bits 3 and 4 and obf0 are, unless the frame is also the IRQx frame.
- R7: The IRQx frame number is xslot, and its request is control bit 5 AND obf1. With bit 7 = 0, a request floats for three clocks and no request gives low, high, float. With bit 7 = 1 the two patterns swap.
- R8: Let E0 be the clock edge that samples the first high after a valid start run. Phase p (0 to 2) of frame n is driven in the cycle that follows edge E0+1+3n+p. A driven high always comes right after a driven low and is followed by a release.
- R9: While frames are being counted, a low run of exactly 2 samples selects quiet mode, and a run of 3 or more selects continuous mode. In both cases the block goes idle and drives nothing until the next start. Reset selects continuous mode.
- R10: In quiet mode, while idle with the line high, a rising edge of the aggregate request drives the line low for exactly one cycle. That cycle follows the edge that sees the rise. The aggregate request is (bit 3 OR bit 4) AND obf0 AND NOT bit 6, OR'd with bit 5 AND obf1. In continuous mode a rising request gives no pulse.
- R11: With bits 0 and 2 both set, clkrun_oe is 1 from the cycle after the first edge that sees them. When bit 2 clears, clkrun_oe returns to 0.
- R12: With bits 0 and 1 set, clkrun_oe goes to 1 at the edge that sees the aggregate request with clkrun_in high. It stays at 1 while the request lasts, even though the line then reads low, and it drops at the edge after the request clears. If clkrun_in is low when the request rises, clkrun_oe stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 8 | Control register write data |
| obf0 | input | 1 | Output buffer 0 full flag |
| obf1 | input | 1 | Output buffer 1 full flag |
| xslot | input | 4 | Frame number used for IRQx |
| sirq_in | input | 1 | Sampled level of the IRQ/data line |
| sirq_oe | output | 1 | Drive enable for the IRQ/data line |
| sirq_out | output | 1 | Level driven on the IRQ/data line when enabled |
| clkrun_in | input | 1 | Sampled level of the clock-run line |
| clkrun_oe | output | 1 | Pull the clock-run line low |

## Verification
The frame function is tried with every combination of the three routing bits, the mute bit, the polarity bit and the two flags. The start-run length varies over 4 to 8, and the IRQx frame number is rotated away from frames 1 and 12. Each frame slot from 0 to 15 is compared in every phase. This separates routing errors, frame-number errors, phase-order errors, polarity inversion, and an ignored mute bit, which would each drive the wrong slot or the wrong pattern. Start runs of 3 and 9 show that the length window is enforced. Stop runs of 2 and 3, each followed by a rising request, separate the quiet pulse from continuous silence. The clock-run checks set the sampled line high and low so that a restart request can be told apart from unconditional drive.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic {
    TRK_IDLE   = 1'b0,
    TRK_FRAMES = 1'b1
  } trk_state_t;

  // control register layout, msb first
  typedef struct packed {
    logic xpol;     // bit7: IRQx polarity
    logic mute;     // bit6: IRQ1/IRQ12 frames floated
    logic rx;       // bit5: obf1 routed to IRQx frame
    logic r12;      // bit4: obf0 routed to IRQ12 frame
    logic r1;       // bit3: obf0 routed to IRQ1 frame
    logic inhibit;  // bit2: hold clock-run low
    logic restart;  // bit1: clock restart requests allowed
    logic en;       // bit0: interface enable
  } ctl_t;

endpackage

// File: rtl/sirq_ctl_reg.sv
module sirq_ctl_reg
  import sirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       obf0,
  input  logic       obf1,
  output ctl_t       ctl,
  output logic       req_any
);

  ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (rst)     ctl_q <= '0;
    else if (we) ctl_q <= ctl_t'(wdata);
  end

  assign ctl = ctl_q;

  // aggregate request used by quiet-mode start and clock restart
  assign req_any = ((ctl_q.r1 | ctl_q.r12) & obf0 & ~ctl_q.mute) | (ctl_q.rx & obf1);

  AST_REG_CLEARS: assert property (@(posedge clk) rst |=> (ctl_q == '0)); // R1

endmodule

// File: rtl/sirq_frame_track.sv
module sirq_frame_track
  import sirq_pkg::*;
#(
  parameter int FRM_W     = 5,
  parameter int CNT_W     = 4,
  parameter int START_MIN = 4,
  parameter int START_MAX = 8,
  parameter int STOP_QUIET = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             line_in,
  input  logic             req_any,
  output logic             in_frames,
  output logic [FRM_W-1:0] frm,
  output logic [1:0]       ph,
  output logic             kick
);

  localparam logic [CNT_W-1:0] RUN_MIN  = CNT_W'(START_MIN);
  localparam logic [CNT_W-1:0] RUN_MAX  = CNT_W'(START_MAX);
  localparam logic [CNT_W-1:0] RUN_QT   = CNT_W'(STOP_QUIET);
  localparam logic [FRM_W-1:0] FRM_LAST = '1;

  trk_state_t       st_q;
  logic [FRM_W-1:0] frm_q;
  logic [1:0]       ph_q;
  logic [CNT_W-1:0] low_q;
  logic             quiet_q;
  logic             req_q;
  logic [CNT_W-1:0] low_inc;

  assign low_inc = (low_q == '1) ? low_q : low_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= TRK_IDLE;
      frm_q   <= '0;
      ph_q    <= '0;
      low_q   <= '0;
      quiet_q <= 1'b0;
      req_q   <= 1'b0;
    end else if (!en) begin
      st_q  <= TRK_IDLE;
      frm_q <= '0;
      ph_q  <= '0;
      low_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= req_any;
      case (st_q)
        TRK_IDLE: begin
          if (!line_in) begin
            low_q <= low_inc;
          end else begin
            if (low_q >= RUN_MIN && low_q <= RUN_MAX) begin
              st_q  <= TRK_FRAMES;
              frm_q <= '0;
              ph_q  <= '0;
            end
            low_q <= '0;
          end
        end
        TRK_FRAMES: begin
          if (ph_q == 2'd2) begin
            ph_q <= '0;
            if (frm_q != FRM_LAST) frm_q <= frm_q + 1'b1;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
          if (!line_in) begin
            low_q <= low_inc;
          end else begin
            if (low_q >= RUN_QT) begin
              st_q    <= TRK_IDLE;
              quiet_q <= (low_q == RUN_QT);
            end
            low_q <= '0;
          end
        end
        default: st_q <= TRK_IDLE;
      endcase
    end
  end

  assign in_frames = (st_q == TRK_FRAMES);
  assign frm       = frm_q;
  assign ph        = ph_q;
  assign kick      = en & (st_q == TRK_IDLE) & quiet_q & req_any & ~req_q & line_in & (low_q == '0);

  AST_START_RUN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (st_q == TRK_FRAMES && $past(st_q) == TRK_IDLE) |-> ($past(low_q) >= RUN_MIN && $past(low_q) <= RUN_MAX)); // R3

  AST_STOP_ENDS_FRAMES: assert property (@(posedge clk) disable iff (rst)
    (en && st_q == TRK_FRAMES && line_in && low_q >= RUN_QT) |=> (st_q == TRK_IDLE)); // R9

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> (st_q == TRK_IDLE)); // R2

endmodule

// File: rtl/sirq_slot_drive.sv
module sirq_slot_drive #(
  parameter int FRM_W  = 5,
  parameter int SLOT_W = 4,
  parameter int IRQ_A  = 1,
  parameter int IRQ_B  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              mute,
  input  logic              r1,
  input  logic              r12,
  input  logic              rx,
  input  logic              xpol,
  input  logic              obf0,
  input  logic              obf1,
  input  logic [SLOT_W-1:0] xslot,
  input  logic              in_frames,
  input  logic [FRM_W-1:0]  frm,
  input  logic [1:0]        ph,
  input  logic              kick,
  output logic              sirq_oe,
  output logic              sirq_out
);

  localparam logic [FRM_W-1:0] SLOT_A = FRM_W'(IRQ_A);
  localparam logic [FRM_W-1:0] SLOT_B = FRM_W'(IRQ_B);

  logic is_a, is_b, is_x, xreq, want;
  logic oe_q, out_q, lh_q;

  assign is_a = (frm == SLOT_A);
  assign is_b = (frm == SLOT_B);
  assign is_x = (frm == FRM_W'(xslot));
  assign xreq = rx & obf1;
  assign want = (is_a & ~mute & r1 & obf0) |
                (is_b & ~mute & r12 & obf0) |
                (is_x & (xpol ? xreq : ~xreq));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      oe_q  <= 1'b0;
      out_q <= 1'b1;
      lh_q  <= 1'b0;
    end else if (kick) begin
      oe_q  <= 1'b1;
      out_q <= 1'b0;
    end else if (in_frames) begin
      case (ph)
        2'd0: begin
          oe_q  <= want;
          out_q <= 1'b0;
          lh_q  <= want;
        end
        2'd1: begin
          oe_q  <= lh_q;
          out_q <= 1'b1;
        end
        default: begin
          oe_q  <= 1'b0;
          out_q <= 1'b1;
        end
      endcase
    end else begin
      oe_q  <= 1'b0;
      out_q <= 1'b1;
    end
  end

  assign sirq_oe  = oe_q;
  assign sirq_out = out_q;

  AST_HIGH_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    (oe_q && out_q) |-> $past(oe_q && !out_q)); // R8

  AST_HIGH_THEN_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (oe_q && out_q) |=> !oe_q); // R8

  AST_MUTED_FRAMES: assert property (@(posedge clk) disable iff (rst)
    (in_frames && !kick && ph == 2'd0 && mute && (is_a || is_b) && !is_x) |=> !oe_q); // R6

  AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !en |=> !oe_q); // R2

endmodule

// File: rtl/sirq_clkrun.sv
module sirq_clkrun (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic restart,
  input  logic inhibit,
  input  logic req_any,
  input  logic clkrun_in,
  output logic clkrun_oe
);

  logic pull_q;

  // once pulling for restart, own low level must not release the pull
  always_ff @(posedge clk) begin
    if (rst) pull_q <= 1'b0;
    else     pull_q <= en & (inhibit | (restart & req_any & (clkrun_in | pull_q)));
  end

  assign clkrun_oe = pull_q;

  AST_INHIBIT_PULLS: assert property (@(posedge clk) disable iff (rst)
    (en && inhibit) |=> clkrun_oe); // R11

  AST_NO_CAUSE_NO_PULL: assert property (@(posedge clk) disable iff (rst)
    (!inhibit && !req_any) |=> !clkrun_oe); // R12

  AST_CLKRUN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> !clkrun_oe); // R2

endmodule

// File: rtl/sirq_slave.sv
module sirq_slave
  import sirq_pkg::*;
#(
  parameter int FRM_W     = 5,
  parameter int SLOT_W    = 4,
  parameter int CNT_W     = 4,
  parameter int START_MIN = 4,
  parameter int START_MAX = 8,
  parameter int IRQ_A     = 1,
  parameter int IRQ_B     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              obf0,
  input  logic              obf1,
  input  logic [SLOT_W-1:0] xslot,
  input  logic              sirq_in,
  output logic              sirq_oe,
  output logic              sirq_out,
  input  logic              clkrun_in,
  output logic              clkrun_oe
);

  ctl_t             ctl;
  logic             req_any;
  logic             in_frames;
  logic [FRM_W-1:0] frm;
  logic [1:0]       ph;
  logic             kick;

  sirq_ctl_reg u_ctl (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .obf0    (obf0),
    .obf1    (obf1),
    .ctl     (ctl),
    .req_any (req_any)
  );

  sirq_frame_track #(
    .FRM_W     (FRM_W),
    .CNT_W     (CNT_W),
    .START_MIN (START_MIN),
    .START_MAX (START_MAX),
    .STOP_QUIET(2)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .en        (ctl.en),
    .line_in   (sirq_in),
    .req_any   (req_any),
    .in_frames (in_frames),
    .frm       (frm),
    .ph        (ph),
    .kick      (kick)
  );

  sirq_slot_drive #(
    .FRM_W  (FRM_W),
    .SLOT_W (SLOT_W),
    .IRQ_A  (IRQ_A),
    .IRQ_B  (IRQ_B)
  ) u_drive (
    .clk       (clk),
    .rst       (rst),
    .en        (ctl.en),
    .mute      (ctl.mute),
    .r1        (ctl.r1),
    .r12       (ctl.r12),
    .rx        (ctl.rx),
    .xpol      (ctl.xpol),
    .obf0      (obf0),
    .obf1      (obf1),
    .xslot     (xslot),
    .in_frames (in_frames),
    .frm       (frm),
    .ph        (ph),
    .kick      (kick),
    .sirq_oe   (sirq_oe),
    .sirq_out  (sirq_out)
  );

  sirq_clkrun u_clkrun (
    .clk       (clk),
    .rst       (rst),
    .en        (ctl.en),
    .restart   (ctl.restart),
    .inhibit   (ctl.inhibit),
    .req_any   (req_any),
    .clkrun_in (clkrun_in),
    .clkrun_oe (clkrun_oe)
  );

endmodule

// File: tb/sirq_slave_tb_top.sv
`timescale 1ns/1ps
module sirq_slave_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic       obf0, obf1;
  logic [3:0] xslot;
  logic       host_low, host_ckr_low;
  logic       sirq_oe, sirq_out, clkrun_oe;
  logic       sirq_line, clkrun_line;

  // pull-up resolution: any low driver wins, otherwise high
  assign sirq_line   = ((sirq_oe && !sirq_out) || host_low) ? 1'b0 : 1'b1;
  assign clkrun_line = (clkrun_oe || host_ckr_low) ? 1'b0 : 1'b1;

  sirq_slave dut_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .obf0      (obf0),
    .obf1      (obf1),
    .xslot     (xslot),
    .sirq_in   (sirq_line),
    .sirq_oe   (sirq_oe),
    .sirq_out  (sirq_out),
    .clkrun_in (clkrun_line),
    .clkrun_oe (clkrun_oe)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  int    mon_skip = 0;
  logic [1:0] q_exp[$];  // {oe, level}
  string      q_tag[$];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mon_skip > 0) begin
        mon_skip--;
      end else if (q_exp.size() > 0) begin
        logic [1:0] e;
        string t;
        bit ok;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        ok = (sirq_oe == e[1]) && (!e[1] || sirq_out == e[0]);
        chk(ok, t, "frame drive {oe,out}", {sirq_oe, sirq_out}, e);
      end
    end
  end

  function automatic bit want_lh(input int n, input logic [7:0] c, input logic o0, input logic o1, input int xs);
    bit xr;
    xr = c[5] & o1;
    return (n == 1 && !c[6] && c[3] && o0) ||
           (n == 12 && !c[6] && c[4] && o0) ||
           (n == xs && (c[7] ? xr : !xr));
  endfunction

  // driver side: expected pattern of frames 0..15
  task automatic push_frames(input logic [7:0] c, input logic o0, input logic o1, input int xs,
                             input bit all_float, input string ftag);
    for (int n = 0; n < 16; n++) begin
      bit lh;
      string t;
      lh = !all_float && want_lh(n, c, o0, o1, xs);
      if (all_float)          t = ftag;
      else if (n == xs)       t = "R7";
      else if (n == 1)        t = c[6] ? "R6" : "R4";
      else if (n == 12)       t = c[6] ? "R6" : "R5";
      else                    t = "R8";
      for (int p = 0; p < 3; p++) begin
        if (lh && p == 0)      q_exp.push_back(2'b10);
        else if (lh && p == 1) q_exp.push_back(2'b11);
        else                   q_exp.push_back(2'b00);
        q_tag.push_back(t);
      end
    end
  endtask

  // called right after a negedge; holds line low for n samples
  task automatic host_low_for(input int n);
    host_low = 1'b1;
    repeat (n) @(negedge clk);
    host_low = 1'b0;
    #1;
    mon_skip = 1;
  endtask

  task automatic host_start(input int len);
    @(negedge clk);
    host_low_for(len);
  endtask

  task automatic host_stop(input int len);
    wait (q_exp.size() == 0);
    @(negedge clk);
    host_low = 1'b1;
    repeat (len) @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
    obf0 = 1'b0; obf1 = 1'b0; xslot = 4'd5;
    host_low = 1'b0; host_ckr_low = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!sirq_oe, "R1", "sirq_oe after reset", sirq_oe, 0);
    chk(!clkrun_oe, "R1", "clkrun_oe after reset", clkrun_oe, 0);

    // R2: disabled interface ignores everything
    obf0 = 1'b1; obf1 = 1'b1;
    wr_ctl(8'b0011_1110);
    host_start(5);
    push_frames(8'h3E, 1, 1, 5, 1'b1, "R2");
    host_stop(3);
    @(negedge clk);
    chk(!clkrun_oe, "R2", "clkrun_oe while disabled", clkrun_oe, 0);
    chk(!sirq_oe, "R2", "sirq_oe while disabled", sirq_oe, 0);

    // R4..R8 exhaustive over routing, mute, polarity and flags (continuous mode)
    for (int k = 0; k < 128; k++) begin
      logic [7:0] c;
      int xs;
      c = {k[4:0], 3'b001};
      xs = 2 + (k % 12);
      if (xs >= 12) xs++;
      @(negedge clk);
      obf0 = k[5];
      obf1 = k[6];
      xslot = 4'(xs);
      wr_ctl(c);
      host_start(4 + (k % 5));   // R3: every legal start length
      push_frames(c, k[5], k[6], xs, 1'b0, "");
      host_stop(3);
      repeat (3) @(negedge clk);
    end

    // R3: start runs outside 4..8 are ignored
    obf0 = 1'b1; obf1 = 1'b0; xslot = 4'd7;
    wr_ctl(8'h09);
    host_start(3);
    push_frames(8'h09, 1, 0, 7, 1'b1, "R3");
    wait (q_exp.size() == 0);
    repeat (3) @(negedge clk);
    host_start(9);
    push_frames(8'h09, 1, 0, 7, 1'b1, "R3");
    wait (q_exp.size() == 0);
    repeat (3) @(negedge clk);

    // R9: stop of 2 selects quiet mode
    obf0 = 1'b0;
    host_start(4);
    push_frames(8'h09, 0, 0, 7, 1'b0, "");
    host_stop(2);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!sirq_oe, "R9", "no drive after stop", sirq_oe, 0);
    end
    // R10: rising request in quiet mode gives one low clock
    obf0 = 1'b1;
    @(negedge clk);
    chk(sirq_oe && !sirq_out, "R10", "quiet start pulse {oe,out}", {sirq_oe, sirq_out}, 2);
    host_low = 1'b1;
    @(negedge clk);
    chk(!sirq_oe, "R10", "pulse lasts one cycle", sirq_oe, 0);
    repeat (3) @(negedge clk);
    host_low = 1'b0;
    #1;
    mon_skip = 1;
    push_frames(8'h09, 1, 0, 7, 1'b0, "");
    host_stop(3);
    repeat (3) @(negedge clk);
    // R10: continuous mode, no pulse
    obf0 = 1'b0;
    @(negedge clk);
    obf0 = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(!sirq_oe, "R10", "no pulse in continuous mode", sirq_oe, 0);
    end

    // R11: clock-stop inhibit
    obf0 = 1'b0;
    wr_ctl(8'h05);
    @(negedge clk);
    chk(clkrun_oe, "R11", "inhibit pulls clkrun", clkrun_oe, 1);
    chk(!clkrun_line, "R11", "clkrun line level", clkrun_line, 0);
    wr_ctl(8'h01);
    @(negedge clk);
    chk(!clkrun_oe, "R11", "inhibit cleared", clkrun_oe, 0);

    // R12: clock restart request
    wr_ctl(8'h0B);
    @(negedge clk);
    chk(!clkrun_oe, "R12", "no request no pull", clkrun_oe, 0);
    obf0 = 1'b1;
    @(negedge clk);
    chk(clkrun_oe, "R12", "restart pull on request", clkrun_oe, 1);
    @(negedge clk);
    chk(clkrun_oe, "R12", "pull held while request", clkrun_oe, 1);
    obf0 = 1'b0;
    @(negedge clk);
    chk(!clkrun_oe, "R12", "pull dropped after request", clkrun_oe, 0);
    host_ckr_low = 1'b1;
    @(negedge clk);
    obf0 = 1'b1;
    @(negedge clk);
    chk(!clkrun_oe, "R12", "clock running, no pull", clkrun_oe, 0);
    host_ckr_low = 1'b0;
    obf0 = 1'b0;

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule